// File: doc/BRIEF.md
# Chunked Streaming Vector Add/Subtract Unit

This block computes c(i) = b(i) + a(i), or c(i) = b(i) - a(i), for every element of a vector of any length N. One command carries the length, the operation and two broadcast flags. The two operand streams then arrive over valid/ready handshakes, and the results leave a fixed-depth pipeline at one element per clock. When an operand is marked as broadcast, its stream is left untouched and a scalar taken with the command is used for every element.

The element count is cut into chunks of at most MAXVL (64) elements. Each result carries an end-of-chunk flag and an end-of-vector flag, so a destination that writes whole register-length chunks knows where each chunk ends. Each result is also offered on a chain port, in the same cycle it is delivered, so a second functional unit can take the element without an intermediate register. When the destination stalls, the whole pipeline freezes and no element is lost. A done pulse marks the end of each command.

Top module: `vstream_add`

## Requirements
- R1: With `cmd_op` = 0, each result equals b(i) + a(i) modulo 2^DATA_W, and results leave in element order.
- R2: With `cmd_op` = 1, each result equals b(i) - a(i) modulo 2^DATA_W.
- R3: When `cmd_a_bcast` (or `cmd_b_bcast`) is 1, `a_ready` (or `b_ready`) stays 0 for the whole command. `cmd_a_scalar` (or `cmd_b_scalar`) is then used as that operand for every element.
- R4: With no stall, the first result is valid exactly DEPTH (4) cycles after the cycle of the first operand handshake. The following results come out on consecutive cycles.
- R5: `res_eoc` is 1 on element indices 63, 127, ... (index mod 64 = 63) and on the final element. `res_eov` is 1 only on the final element.
- R6: While `res_valid` is 1 and `res_ready` is 0, the result and its flags hold unchanged, and `a_ready` and `b_ready` are 0.
- R7: `chain_valid` is 1 exactly in the cycles where a result transfers (`res_valid` and `res_ready`), and `chain_data` equals `res_data` in those cycles.
- R8: `done` is a one-cycle pulse. For N > 0 it comes in the cycle after the final element transfers. For N = 0 it comes in the cycle after the command is accepted, and no result is produced.
- R9: `cmd_ready` is 1 after reset. It is 0 while elements of an accepted vector remain to be issued, except in the cycle that issues the final element, where it is 1.
- R10: Exactly N results are delivered for a command of length N, including lengths above 64 and exact multiples of 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_len | input | LEN_W | Element count N |
| cmd_op | input | 1 | 0 = add, 1 = subtract (b - a) |
| cmd_a_bcast | input | 1 | Use scalar for operand a |
| cmd_b_bcast | input | 1 | Use scalar for operand b |
| cmd_a_scalar | input | DATA_W | Broadcast value for a |
| cmd_b_scalar | input | DATA_W | Broadcast value for b |
| a_valid | input | 1 | Operand a element offered |
| a_ready | output | 1 | Operand a element taken |
| a_data | input | DATA_W | Operand a element |
| b_valid | input | 1 | Operand b element offered |
| b_ready | output | 1 | Operand b element taken |
| b_data | input | DATA_W | Operand b element |
| res_valid | output | 1 | Result element present |
| res_ready | input | 1 | Destination accepts the result |
| res_data | output | DATA_W | Result element |
| res_eoc | output | 1 | Last element of a chunk |
| res_eov | output | 1 | Last element of the vector |
| chain_valid | output | 1 | Result forwarded to the chained unit |
| chain_data | output | DATA_W | Forwarded result |
| done | output | 1 | Command completed pulse |

## Verification
The hardest situation to reach is the cycle in which the final element of one vector issues while a new command is waiting. That cycle shows whether `cmd_ready` opens at exactly that point and at no earlier one. The bench drives operand a one element at a time, with b broadcast, and samples `cmd_ready` before and during the final issue. The chunk boundaries are the other hard case. A 130-element run with a throttled operand stream and a stalling destination places the 64-element boundaries under backpressure. A separate 64-element run checks the case where the chunk end and the vector end fall on the same element.

// File: rtl/vstream_pkg.sv
package vstream_pkg;
  typedef enum logic {VOP_ADD = 1'b0, VOP_SUB = 1'b1} vop_e;
endpackage

// File: rtl/vstream_issue.sv
module vstream_issue #(
  parameter int LEN_W  = 16,
  parameter int DATA_W = 16,
  parameter int MAXVL  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_op,
  input  logic              cmd_a_bcast,
  input  logic              cmd_b_bcast,
  input  logic [DATA_W-1:0] cmd_a_scalar,
  input  logic [DATA_W-1:0] cmd_b_scalar,
  input  logic              a_valid,
  output logic              a_ready,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic [DATA_W-1:0] b_data,
  input  logic              adv,
  input  logic              pipe_has_last,
  output logic              iss_valid,
  output logic [DATA_W-1:0] iss_a,
  output logic [DATA_W-1:0] iss_b,
  output vstream_pkg::vop_e iss_op,
  output logic              iss_eoc,
  output logic              iss_eov,
  output logic              zero_accept
);
  localparam int POS_W = (MAXVL > 1) ? $clog2(MAXVL) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(MAXVL - 1);

  logic              busy;
  logic [LEN_W-1:0]  rem;
  logic [POS_W-1:0]  pos;
  vstream_pkg::vop_e op_q;
  logic              a_bc_q, b_bc_q;
  logic [DATA_W-1:0] a_sc_q, b_sc_q;
  logic              a_ok, b_ok, final_fire, accept;

  assign a_ok       = a_bc_q || a_valid;
  assign b_ok       = b_bc_q || b_valid;
  assign iss_valid  = busy && adv && a_ok && b_ok;
  assign iss_eov    = (rem == LEN_W'(1));
  assign iss_eoc    = iss_eov || (pos == POS_LAST);
  assign final_fire = iss_valid && iss_eov;
  assign iss_a      = a_bc_q ? a_sc_q : a_data;
  assign iss_b      = b_bc_q ? b_sc_q : b_data;
  assign iss_op     = op_q;
  assign a_ready    = busy && adv && b_ok && !a_bc_q;
  assign b_ready    = busy && adv && a_ok && !b_bc_q;

  // a zero-length command waits until no final element is in flight
  assign cmd_ready   = (!busy || final_fire) &&
                       ((cmd_len != '0) || (!busy && !pipe_has_last));
  assign accept      = cmd_valid && cmd_ready;
  assign zero_accept = accept && (cmd_len == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      rem    <= '0;
      pos    <= '0;
      op_q   <= vstream_pkg::VOP_ADD;
      a_bc_q <= 1'b0;
      b_bc_q <= 1'b0;
      a_sc_q <= '0;
      b_sc_q <= '0;
    end else if (accept) begin
      busy   <= (cmd_len != '0);
      rem    <= cmd_len;
      pos    <= '0;
      op_q   <= vstream_pkg::vop_e'(cmd_op);
      a_bc_q <= cmd_a_bcast;
      b_bc_q <= cmd_b_bcast;
      a_sc_q <= cmd_a_scalar;
      b_sc_q <= cmd_b_scalar;
    end else if (iss_valid) begin
      rem  <= rem - LEN_W'(1);
      busy <= !iss_eov;
      pos  <= iss_eoc ? '0 : pos + POS_W'(1);
    end
  end
endmodule

// File: rtl/vstream_pipe.sv
module vstream_pipe #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  vstream_pkg::vop_e in_op,
  input  logic              in_eoc,
  input  logic              in_eov,
  input  logic              out_ready,
  output logic              adv,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_eoc,
  output logic              out_eov,
  output logic              has_last
);
  function automatic logic [DATA_W-1:0] combine(vstream_pkg::vop_e op,
                                                logic [DATA_W-1:0] a,
                                                logic [DATA_W-1:0] b);
    return (op == vstream_pkg::VOP_SUB) ? (b - a) : (b + a);
  endfunction

  logic              st_v   [DEPTH];
  logic [DATA_W-1:0] st_d   [DEPTH];
  logic              st_eoc [DEPTH];
  logic              st_eov [DEPTH];

  assign adv = !st_v[DEPTH-1] || out_ready;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st_v[0] <= 1'b0;
        end else if (adv) begin
          st_v[0] <= in_valid;
        end
        if (adv) begin
          st_d[0]   <= combine(in_op, in_a, in_b);
          st_eoc[0] <= in_eoc;
          st_eov[0] <= in_eov;
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st_v[g] <= 1'b0;
        end else if (adv) begin
          st_v[g] <= st_v[g-1];
        end
        if (adv) begin
          st_d[g]   <= st_d[g-1];
          st_eoc[g] <= st_eoc[g-1];
          st_eov[g] <= st_eov[g-1];
        end
      end
    end
  end

  always_comb begin
    has_last = 1'b0;
    for (int i = 0; i < DEPTH; i++) has_last = has_last | (st_v[i] & st_eov[i]);
  end

  assign out_valid = st_v[DEPTH-1];
  assign out_data  = st_d[DEPTH-1];
  assign out_eoc   = st_eoc[DEPTH-1];
  assign out_eov   = st_eov[DEPTH-1];
endmodule

// File: rtl/vstream_add.sv
module vstream_add #(
  parameter int LEN_W  = 16,
  parameter int DATA_W = 16,
  parameter int MAXVL  = 64,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_op,
  input  logic              cmd_a_bcast,
  input  logic              cmd_b_bcast,
  input  logic [DATA_W-1:0] cmd_a_scalar,
  input  logic [DATA_W-1:0] cmd_b_scalar,
  input  logic              a_valid,
  output logic              a_ready,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic [DATA_W-1:0] b_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_eoc,
  output logic              res_eov,
  output logic              chain_valid,
  output logic [DATA_W-1:0] chain_data,
  output logic              done
);
  logic              adv, pipe_has_last, zero_accept;
  logic              iss_valid, iss_eoc, iss_eov;
  logic [DATA_W-1:0] iss_a, iss_b;
  vstream_pkg::vop_e iss_op;
  logic              out_fire, done_q;

  vstream_issue #(.LEN_W(LEN_W), .DATA_W(DATA_W), .MAXVL(MAXVL)) u_iss (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_len(cmd_len), .cmd_op(cmd_op),
    .cmd_a_bcast(cmd_a_bcast), .cmd_b_bcast(cmd_b_bcast),
    .cmd_a_scalar(cmd_a_scalar), .cmd_b_scalar(cmd_b_scalar),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .adv(adv), .pipe_has_last(pipe_has_last),
    .iss_valid(iss_valid), .iss_a(iss_a), .iss_b(iss_b), .iss_op(iss_op),
    .iss_eoc(iss_eoc), .iss_eov(iss_eov), .zero_accept(zero_accept)
  );

  vstream_pipe #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(iss_valid), .in_a(iss_a), .in_b(iss_b), .in_op(iss_op),
    .in_eoc(iss_eoc), .in_eov(iss_eov), .out_ready(res_ready),
    .adv(adv), .out_valid(res_valid), .out_data(res_data),
    .out_eoc(res_eoc), .out_eov(res_eov), .has_last(pipe_has_last)
  );

  assign out_fire    = res_valid && res_ready;
  assign chain_valid = out_fire;
  assign chain_data  = res_data;

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= (out_fire && res_eov) || zero_accept;
  end
  assign done = done_q;
endmodule

// File: rtl/vstream_add_chk.sv
module vstream_add_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_a_bcast,
  input logic              cmd_b_bcast,
  input logic              a_ready,
  input logic              b_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data,
  input logic              res_eoc,
  input logic              res_eov,
  input logic              done,
  input logic              zero_accept
);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_eoc) && $stable(res_eov));

  a_r6_inputs_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !a_ready && !b_ready);

  a_r5_eov_ends_chunk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_eov |-> res_eoc);

  a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    zero_accept |=> done && !res_valid);

  a_r3_bcast_a: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_a_bcast |=> !a_ready);

  a_r3_bcast_b: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_b_bcast |=> !b_ready);
endmodule

bind vstream_add vstream_add_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_a_bcast(cmd_a_bcast), .cmd_b_bcast(cmd_b_bcast),
  .a_ready(a_ready), .b_ready(b_ready), .res_valid(res_valid), .res_ready(res_ready),
  .res_data(res_data), .res_eoc(res_eoc), .res_eov(res_eov), .done(done),
  .zero_accept(zero_accept)
);

// File: tb/vstream_add_bench.sv
module vstream_add_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int LW = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [LW-1:0] cmd_len = '0;
  logic cmd_op = 1'b0, cmd_a_bcast = 1'b0, cmd_b_bcast = 1'b0;
  logic [DW-1:0] cmd_a_scalar = '0, cmd_b_scalar = '0;
  logic a_valid = 1'b0, a_ready, b_valid = 1'b0, b_ready;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic res_valid, res_ready = 1'b0, res_eoc, res_eov, chain_valid, done;
  logic [DW-1:0] res_data, chain_data;

  int tcount = 0, fcount = 0, cyc = 0;
  int acc_cyc, first_in, first_out, last_out;
  bit acc_done;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  vstream_add u_vstream_add (.*);

  function automatic logic [DW-1:0] aval(int i); return DW'(i * 4099 + 123); endfunction
  function automatic logic [DW-1:0] bval(int i); return DW'(i * 911 + 60000); endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tcount++;
    if (!ok) begin
      fcount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_cmd(int len, bit op, bit abc, bit bbc, logic [DW-1:0] asc, logic [DW-1:0] bsc);
    acc_done = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_len = LW'(len); cmd_op = op;
    cmd_a_bcast = abc; cmd_b_bcast = bbc; cmd_a_scalar = asc; cmd_b_scalar = bsc;
    forever begin
      #1;
      if (cmd_ready) break;
      @(negedge clk);
    end
    acc_cyc = cyc; acc_done = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic drive_a(int n, bit throttle);
    int idx = 0, k = 0;
    bit first = 1;
    wait (acc_done);
    while (idx < n) begin
      @(negedge clk);
      k++;
      a_valid = !(throttle && (k % 4 == 0));
      a_data = aval(idx);
      #1;
      if (a_valid && a_ready) begin
        if (first) begin first_in = cyc; first = 0; end
        idx++;
      end
    end
    @(negedge clk);
    a_valid = 0;
  endtask

  task automatic drive_b(int n);
    int idx = 0;
    wait (acc_done);
    while (idx < n) begin
      @(negedge clk);
      b_valid = 1; b_data = bval(idx);
      #1;
      if (b_valid && b_ready) idx++;
    end
    @(negedge clk);
    b_valid = 0;
  endtask

  task automatic monitor(int n, bit op, bit abc, bit bbc, logic [DW-1:0] asc, logic [DW-1:0] bsc, bit stall);
    int got = 0, k = 0, lastx = -10;
    bit held = 0, seen_done = 0;
    logic [DW-1:0] hv, aa, bb, exp;
    first_out = -1;
    while (!seen_done) begin
      @(negedge clk);
      k++;
      res_ready = stall ? (k % 3 != 2) : 1'b1;
      #1;
      if (held) chk(res_valid && res_data == hv, "R6 hold", res_data, hv);
      held = res_valid && !res_ready; hv = res_data;
      chk(chain_valid == (res_valid && res_ready), "R7 chain_valid", chain_valid, res_valid && res_ready);
      if (done) begin
        seen_done = 1;
        chk(got == n, "R10 count", got, n);
        if (n == 0) chk(cyc == acc_cyc + 1, "R8 zero done", cyc, acc_cyc + 1);
        else        chk(cyc == lastx + 1, "R8 done timing", cyc, lastx + 1);
      end
      if (res_valid && res_ready) begin
        aa = abc ? asc : aval(got);
        bb = bbc ? bsc : bval(got);
        exp = op ? DW'(bb - aa) : DW'(bb + aa);
        chk(res_data == exp, op ? "R2 sub" : "R1 add", res_data, exp);
        chk(chain_data == exp, "R7 chain_data", chain_data, exp);
        chk(res_eoc == ((got % 64 == 63) || (got == n - 1)), "R5 eoc", res_eoc, (got % 64 == 63) || (got == n - 1));
        chk(res_eov == (got == n - 1), "R5 eov", res_eov, got == n - 1);
        if (first_out < 0) first_out = cyc;
        last_out = cyc; lastx = cyc;
        got++;
      end
    end
    res_ready = 0;
  endtask

  task automatic run_vec(int n, bit op, bit abc, bit bbc, logic [DW-1:0] asc, logic [DW-1:0] bsc,
                         bit stall, bit throttle);
    fork
      send_cmd(n, op, abc, bbc, asc, bsc);
      if (!abc) drive_a(n, throttle);
      if (!bbc) drive_b(n);
      monitor(n, op, abc, bbc, asc, bsc, stall);
    join
  endtask

  task automatic test_reset;
    @(negedge clk); #1;
    chk(cmd_ready == 1, "R9 reset cmd_ready", cmd_ready, 1);
    chk(res_valid == 0, "R6 reset res_valid", res_valid, 0);
    chk(done == 0, "R8 reset done", done, 0);
  endtask

  task automatic test_latency; // R4, R1
    run_vec(10, 0, 0, 0, 0, 0, 0, 0);
    chk(first_out - first_in == DEPTH, "R4 latency", first_out - first_in, DEPTH);
    chk(last_out - first_out == 9, "R4 throughput", last_out - first_out, 9);
  endtask

  task automatic test_cmd_ready; // R9
    fork
      send_cmd(2, 0, 0, 1, 0, 16'd7);
      monitor(2, 0, 0, 1, 0, 16'd7, 0);
      begin
        wait (acc_done);
        @(negedge clk); a_valid = 0; #1;
        chk(cmd_ready == 0, "R9 busy", cmd_ready, 0);
        a_valid = 1; a_data = aval(0); #1;
        chk(cmd_ready == 0, "R9 not final", cmd_ready, 0);
        chk(b_ready == 0, "R3 b_ready", b_ready, 0);
        @(negedge clk); a_data = aval(1); #1;
        chk(cmd_ready == 1, "R9 final issue", cmd_ready, 1);
        @(negedge clk); a_valid = 0;
      end
    join
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tcount++; fcount++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", tcount, fcount);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    test_reset();
    test_latency();
    run_vec(7, 1, 0, 0, 0, 0, 0, 0);               // R2
    run_vec(20, 0, 1, 0, 16'd500, 0, 1, 0);        // R3, R6
    run_vec(5, 1, 0, 1, 0, 16'd3, 0, 0);           // R3, R2
    run_vec(130, 0, 0, 0, 0, 0, 1, 1);             // R5, R10, R6
    run_vec(64, 1, 0, 0, 0, 0, 0, 0);              // R5
    run_vec(0, 0, 0, 0, 0, 0, 0, 0);               // R8
    test_cmd_ready();                              // R9
    run_vec(3, 0, 1, 1, 16'd40000, 16'd30000, 0, 0); // R3 both broadcast
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", tcount, fcount);
    $finish;
  end
endmodule